// File: doc/BRIEF.md
# Wireless Receiver Power-Control Supervisor

This block runs the digital side of a wireless power receiver. It sees the receiver's operating conditions as already digitised flags and decides what the receiver says to the transmitter and when it says it. The flags cover the external adapter, the two enable pins, the thermistor window and the control pin, die temperature, a current-limit resistor that is too small, whether the rectifier voltage sits on its target, and which band of the maximum output current the load is in. It produces a one-byte-payload packet request (header plus payload) for a downstream serializer, a rectifier target code, an output enable and a power-good flag, and the switch control for the adapter path.

When the link comes up, the block either sends the three handshake packets or, if a shutdown condition is already present, sends a single end-power packet in their place. After the handshake it sends control-error packets. The cadence is fast while the rectifier is off target and slow once it is on target. The output is enabled only after the rectifier first reaches the no-load target. From then on the target code follows the load band. Shutdown conditions are mapped to end-power reason codes through a fixed priority. All intervals are counted in clock cycles and set by parameters; with a 1 ms tick the defaults give 30 ms and 250 ms.

Top module: `wpr_supervisor`

## Requirements
- R1: After link_up rises with no shutdown condition, the first three packets are header 0x01 (payload SIG_STRENGTH), header 0x51 (payload CFG_BYTE) and header 0x71 (payload ID_BYTE), in that order.
- R2: If a shutdown condition is present when the link comes up, exactly one packet is sent: an end-power packet with header 0x02. No handshake packet is sent.
- R3: out_en and pwr_good stay low until vrect_ok has been seen high after the handshake. They rise on the clock edge that samples vrect_ok high.
- R4: vrect_code is 0 (the highest rectifier level) whenever out_en is low. While out_en is high, vrect_code equals load_band, where 0 means 0-10 %, 1 means 10-20 %, 2 means 20-40 % and 3 means above 40 % of maximum current, and higher codes mean lower voltage.
- R5: After the handshake, control-error packets (header 0x03, payload vrect_err) are spaced FAST_CYC cycles apart while vrect_ok is low and SLOW_CYC cycles apart while it is high.
- R6: The end-power reason is 0x00 for an adapter with both enables low; 0x01 for ctrl_high or both enables high; 0x02 for die_hot or ilim_low; and 0x03 for ts_hot, ts_cold or ctrl_gnd.
- R7: If vrect_ok stays low for NOCONV_CYC consecutive cycles after the handshake, an end-power packet with reason 0x08 is sent. It is accepted NOCONV_CYC+2 cycles after the identification packet.
- R8: When several conditions are true, the reason is chosen in the priority order 0x02, 0x03, 0x01, 0x00, 0x08.
- R9: With en_a high and en_b low, adapter_sw is high and no packet of any kind is issued, and out_en stays low. With en_a low and en_b high, the adapter is ignored: adapter_sw is low and the session proceeds with no end-power packet.
- R10: While pkt_valid is high and pkt_ready is low, pkt_valid, pkt_hdr and pkt_data hold their values.
- R11: After an end-power packet has been accepted, out_en is low and nothing more is sent until link_up falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Transmitter power present; a rising edge starts a session |
| adapter_det | input | 1 | Wired adapter voltage detected |
| en_a | input | 1 | First mode-select pin |
| en_b | input | 1 | Second mode-select pin |
| ts_hot | input | 1 | Thermistor beyond the hot threshold |
| ts_cold | input | 1 | Thermistor beyond the cold threshold |
| ctrl_high | input | 1 | Control pin driven high by a host (done) |
| ctrl_gnd | input | 1 | Control pin pulled to ground (fault) |
| die_hot | input | 1 | Die over-temperature |
| ilim_low | input | 1 | Current-limit resistor below its minimum |
| vrect_ok | input | 1 | Rectifier voltage on its target |
| load_band | input | BAND_W | Output-current band of the maximum setting |
| vrect_err | input | 8 | Control-error value to report |
| pkt_ready | input | 1 | Serializer accepts the offered packet |
| pkt_valid | output | 1 | Packet offered |
| pkt_hdr | output | 8 | Packet header |
| pkt_data | output | 8 | Packet payload byte |
| vrect_code | output | BAND_W | Rectifier voltage target code |
| out_en | output | 1 | Output supply enabled |
| pwr_good | output | 1 | Power-good indication |
| adapter_sw | output | 1 | Turns on the adapter pass switch |

## Verification
The bench targets the points where the decision depends on timing. A start-up with a fault already present must not leak a handshake packet first. The control-error cadence must change at the moment the rectifier reaches its target. A design that ignores the fault at start-up, or that keeps the fast rate, shows up as a wrong header or a wrong gap between packets. Conflicting conditions are applied together so that an inverted priority reports the wrong reason. A serializer that stalls must not see the offered packet change. The forced-adapter mode must stay completely silent, and a design that treats it as a normal shutdown sends an end-power packet that the bench catches. The non-convergence timeout is checked to the exact cycle, so an off-by-one counter is caught.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SIG,
      ST_CFG,
      ST_ID,
      ST_CONV,
      ST_RUN,
      ST_TERM,
      ST_HALT
   } wpr_state_e;

   localparam logic [7:0] HDR_SIGSTR = 8'h01;
   localparam logic [7:0] HDR_EPT    = 8'h02;
   localparam logic [7:0] HDR_CTLERR = 8'h03;
   localparam logic [7:0] HDR_CONFIG = 8'h51;
   localparam logic [7:0] HDR_IDENT  = 8'h71;

   localparam logic [7:0] RSN_ADAPTER  = 8'h00;
   localparam logic [7:0] RSN_DONE     = 8'h01;
   localparam logic [7:0] RSN_FAULT    = 8'h02;
   localparam logic [7:0] RSN_OVERTEMP = 8'h03;
   localparam logic [7:0] RSN_NORESP   = 8'h08;

   typedef struct packed {
      logic       adapter;
      logic [1:0] en;
      logic       ts_hot;
      logic       ts_cold;
      logic       ctrl_high;
      logic       ctrl_gnd;
      logic       die_hot;
      logic       ilim_low;
   } wpr_cond_t;

endpackage

// File: rtl/wpr_cond_stage.sv
module wpr_cond_stage
   import wpr_pkg::*;
#(
   parameter int unsigned BAND_W    = 2,
   parameter bit          REG_FLAGS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wpr_cond_t         cond_i,
   input  logic              ok_i,
   input  logic [BAND_W-1:0] band_i,
   output wpr_cond_t         cond_o,
   output logic              ok_o,
   output logic [BAND_W-1:0] band_o
);

   if (BAND_W < 1) begin : g_bad_band
      $error("BAND_W must be at least 1");
   end

   if (REG_FLAGS) begin : g_reg
      wpr_cond_t         cond_q;
      logic              ok_q;
      logic [BAND_W-1:0] band_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cond_q <= '0;
            ok_q   <= 1'b0;
            band_q <= '0;
         end else begin
            cond_q <= cond_i;
            ok_q   <= ok_i;
            band_q <= band_i;
         end
      end
      assign cond_o = cond_q;
      assign ok_o   = ok_q;
      assign band_o = band_q;
   end else begin : g_pass
      assign cond_o = cond_i;
      assign ok_o   = ok_i;
      assign band_o = band_i;
   end

endmodule

// File: rtl/wpr_fault_arb.sv
module wpr_fault_arb
   import wpr_pkg::*;
(
   input  wpr_cond_t   cond,
   output logic        silent,
   output logic        sd_any,
   output logic [7:0]  reason,
   output logic        adapter_sw
);

   assign silent     = (cond.en == 2'b10);
   assign adapter_sw = silent | ((cond.en == 2'b00) & cond.adapter);

   always_comb begin
      sd_any = 1'b1;
      reason = RSN_ADAPTER;
      if (cond.die_hot || cond.ilim_low) begin
         reason = RSN_FAULT;
      end else if (cond.ts_hot || cond.ts_cold || cond.ctrl_gnd) begin
         reason = RSN_OVERTEMP;
      end else if (cond.ctrl_high || (cond.en == 2'b11)) begin
         reason = RSN_DONE;
      end else if ((cond.en == 2'b00) && cond.adapter) begin
         reason = RSN_ADAPTER;
      end else begin
         sd_any = 1'b0;
      end
   end

endmodule

// File: rtl/wpr_timers.sv
module wpr_timers #(
   parameter int unsigned FAST_CYC   = 30,
   parameter int unsigned SLOW_CYC   = 250,
   parameter int unsigned NOCONV_CYC = 90
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic on_tgt,
   input  logic ce_sent,
   output logic ce_due,
   output logic no_conv
);

   localparam int unsigned CAD_W  = (SLOW_CYC > 1) ? $clog2(SLOW_CYC) : 1;
   localparam int unsigned CONV_W = $clog2(NOCONV_CYC + 1);
   localparam logic [CAD_W-1:0]  CAD_MAX  = CAD_W'(SLOW_CYC - 1);
   localparam logic [CAD_W-1:0]  FAST_LIM = CAD_W'(FAST_CYC - 1);
   localparam logic [CONV_W-1:0] CONV_MAX = CONV_W'(NOCONV_CYC);

   if (FAST_CYC < 1) begin : g_bad_fast
      $error("FAST_CYC must be at least 1");
   end
   if (SLOW_CYC <= FAST_CYC) begin : g_bad_slow
      $error("SLOW_CYC must exceed FAST_CYC");
   end
   if (NOCONV_CYC < 1) begin : g_bad_conv
      $error("NOCONV_CYC must be at least 1");
   end

   logic [CAD_W-1:0]  cad_q;
   logic [CONV_W-1:0] conv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cad_q <= '0;
      end else if (!active || ce_sent) begin
         cad_q <= '0;
      end else if (cad_q < CAD_MAX) begin
         cad_q <= cad_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q <= '0;
      end else if (!active || on_tgt) begin
         conv_q <= '0;
      end else if (conv_q < CONV_MAX) begin
         conv_q <= conv_q + 1'b1;
      end
   end

   assign ce_due  = on_tgt ? (cad_q >= CAD_MAX) : (cad_q >= FAST_LIM);
   assign no_conv = (conv_q == CONV_MAX);

   // R7
   noconv_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      no_conv |-> !$past(on_tgt));

endmodule

// File: rtl/wpr_seq.sv
module wpr_seq
   import wpr_pkg::*;
#(
   parameter logic [7:0] SIG_STRENGTH = 8'h80,
   parameter logic [7:0] CFG_BYTE     = 8'h05,
   parameter logic [7:0] ID_BYTE      = 8'h10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       link_up,
   input  logic       silent,
   input  logic       sd_any,
   input  logic [7:0] reason,
   input  logic       on_tgt,
   input  logic       ce_due,
   input  logic       no_conv,
   input  logic [7:0] err,
   input  logic       pkt_ready,
   output logic       pkt_valid,
   output logic [7:0] pkt_hdr,
   output logic [7:0] pkt_data,
   output logic       active,
   output logic       ce_sent,
   output logic       out_en
);

   wpr_state_e st_q, st_n;
   logic       vld_q, vld_n;
   logic [7:0] hdr_q, hdr_n, dat_q, dat_n;
   logic       free;

   assign free = !vld_q || pkt_ready;

   always_comb begin
      st_n    = st_q;
      vld_n   = vld_q && !pkt_ready;
      hdr_n   = hdr_q;
      dat_n   = dat_q;
      ce_sent = 1'b0;
      if (!link_up) begin
         st_n  = ST_IDLE;
         vld_n = 1'b0;
      end else begin
         case (st_q)
            ST_IDLE, ST_SIG, ST_CFG, ST_ID: begin
               if (free) begin
                  if (silent) begin
                     st_n = ST_HALT;
                  end else if (sd_any) begin
                     st_n  = ST_TERM;
                     vld_n = 1'b1;
                     hdr_n = HDR_EPT;
                     dat_n = reason;
                  end else begin
                     case (st_q)
                        ST_IDLE: begin
                           st_n  = ST_SIG;
                           vld_n = 1'b1;
                           hdr_n = HDR_SIGSTR;
                           dat_n = SIG_STRENGTH;
                        end
                        ST_SIG: begin
                           st_n  = ST_CFG;
                           vld_n = 1'b1;
                           hdr_n = HDR_CONFIG;
                           dat_n = CFG_BYTE;
                        end
                        ST_CFG: begin
                           st_n  = ST_ID;
                           vld_n = 1'b1;
                           hdr_n = HDR_IDENT;
                           dat_n = ID_BYTE;
                        end
                        default: st_n = ST_CONV;
                     endcase
                  end
               end
            end
            ST_CONV, ST_RUN: begin
               if (silent) begin
                  st_n = ST_HALT;
               end else if (free && sd_any) begin
                  st_n  = ST_TERM;
                  vld_n = 1'b1;
                  hdr_n = HDR_EPT;
                  dat_n = reason;
               end else if (free && no_conv) begin
                  st_n  = ST_TERM;
                  vld_n = 1'b1;
                  hdr_n = HDR_EPT;
                  dat_n = RSN_NORESP;
               end else begin
                  if (free && ce_due) begin
                     ce_sent = 1'b1;
                     vld_n   = 1'b1;
                     hdr_n   = HDR_CTLERR;
                     dat_n   = err;
                  end
                  if ((st_q == ST_CONV) && on_tgt) begin
                     st_n = ST_RUN;
                  end
               end
            end
            ST_TERM: begin
               if (free) begin
                  st_n = ST_HALT;
               end
            end
            default: st_n = ST_HALT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         vld_q <= 1'b0;
         hdr_q <= '0;
         dat_q <= '0;
      end else begin
         st_q  <= st_n;
         vld_q <= vld_n;
         hdr_q <= hdr_n;
         dat_q <= dat_n;
      end
   end

   assign pkt_valid = vld_q;
   assign pkt_hdr   = hdr_q;
   assign pkt_data  = dat_q;
   assign active    = (st_q == ST_CONV) || (st_q == ST_RUN);
   assign out_en    = (st_q == ST_RUN);

   // R10
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_ready && link_up) |=>
         (pkt_valid && $stable(pkt_hdr) && $stable(pkt_data)));

   // R9
   silent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (silent && !pkt_valid) |=> !pkt_valid);

   // R11
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_HALT) && !pkt_valid) |=> !pkt_valid);

   // R3
   enable_after_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_en) |-> $past(on_tgt));

endmodule

// File: rtl/wpr_supervisor.sv
module wpr_supervisor
   import wpr_pkg::*;
#(
   parameter int unsigned FAST_CYC     = 30,
   parameter int unsigned SLOW_CYC     = 250,
   parameter int unsigned NOCONV_CYC   = 90,
   parameter int unsigned BAND_W       = 2,
   parameter bit          REG_FLAGS    = 1'b0,
   parameter logic [7:0]  SIG_STRENGTH = 8'h80,
   parameter logic [7:0]  CFG_BYTE     = 8'h05,
   parameter logic [7:0]  ID_BYTE      = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up,
   input  logic              adapter_det,
   input  logic              en_a,
   input  logic              en_b,
   input  logic              ts_hot,
   input  logic              ts_cold,
   input  logic              ctrl_high,
   input  logic              ctrl_gnd,
   input  logic              die_hot,
   input  logic              ilim_low,
   input  logic              vrect_ok,
   input  logic [BAND_W-1:0] load_band,
   input  logic [7:0]        vrect_err,
   input  logic              pkt_ready,
   output logic              pkt_valid,
   output logic [7:0]        pkt_hdr,
   output logic [7:0]        pkt_data,
   output logic [BAND_W-1:0] vrect_code,
   output logic              out_en,
   output logic              pwr_good,
   output logic              adapter_sw
);

   wpr_cond_t         cond_raw, cond_f;
   logic              ok_f;
   logic [BAND_W-1:0] band_f;
   logic              silent, sd_any, active, ce_sent, ce_due, no_conv;
   logic [7:0]        reason;

   assign cond_raw = '{adapter:   adapter_det,
                       en:        {en_a, en_b},
                       ts_hot:    ts_hot,
                       ts_cold:   ts_cold,
                       ctrl_high: ctrl_high,
                       ctrl_gnd:  ctrl_gnd,
                       die_hot:   die_hot,
                       ilim_low:  ilim_low};

   wpr_cond_stage #(.BAND_W(BAND_W), .REG_FLAGS(REG_FLAGS)) cond_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (cond_raw),
      .ok_i   (vrect_ok),
      .band_i (load_band),
      .cond_o (cond_f),
      .ok_o   (ok_f),
      .band_o (band_f)
   );

   wpr_fault_arb arb_i (
      .cond       (cond_f),
      .silent     (silent),
      .sd_any     (sd_any),
      .reason     (reason),
      .adapter_sw (adapter_sw)
   );

   wpr_timers #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC), .NOCONV_CYC(NOCONV_CYC)) tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .on_tgt  (ok_f),
      .ce_sent (ce_sent),
      .ce_due  (ce_due),
      .no_conv (no_conv)
   );

   wpr_seq #(.SIG_STRENGTH(SIG_STRENGTH), .CFG_BYTE(CFG_BYTE), .ID_BYTE(ID_BYTE)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_up   (link_up),
      .silent    (silent),
      .sd_any    (sd_any),
      .reason    (reason),
      .on_tgt    (ok_f),
      .ce_due    (ce_due),
      .no_conv   (no_conv),
      .err       (vrect_err),
      .pkt_ready (pkt_ready),
      .pkt_valid (pkt_valid),
      .pkt_hdr   (pkt_hdr),
      .pkt_data  (pkt_data),
      .active    (active),
      .ce_sent   (ce_sent),
      .out_en    (out_en)
   );

   assign vrect_code = out_en ? band_f : '0;
   assign pwr_good   = out_en;

   // R4
   idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> (vrect_code == '0));

endmodule

// File: tb/wpr_supervisor_tb_top.sv
module wpr_supervisor_tb_top;

   localparam int CLK_P  = 10;
   localparam int FAST   = 6;
   localparam int SLOW   = 20;
   localparam int NOCONV = 40;
   localparam logic [7:0] SS_B  = 8'h8C;
   localparam logic [7:0] CFG_B = 8'h05;
   localparam logic [7:0] ID_B  = 8'h12;

   localparam int M_IDLE = 0, M_SIG = 1, M_CFG = 2, M_ID = 3,
                  M_CONV = 4, M_RUN = 5, M_TERM = 6, M_HALT = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       link_up = 1'b0, adapter_det = 1'b0, en_a = 1'b0, en_b = 1'b0;
   logic       ts_hot = 1'b0, ts_cold = 1'b0, ctrl_high = 1'b0, ctrl_gnd = 1'b0;
   logic       die_hot = 1'b0, ilim_low = 1'b0, vrect_ok = 1'b0;
   logic [1:0] load_band = 2'd0;
   logic [7:0] vrect_err = 8'hF4;
   logic       pkt_ready = 1'b1;
   logic       pkt_valid, out_en, pwr_good, adapter_sw;
   logic [7:0] pkt_hdr, pkt_data;
   logic [1:0] vrect_code;

   int  checks = 0, failures = 0, cyc = 0;
   bit  done = 0;
   logic [7:0] q_h[$], q_d[$];
   int         q_t[$];

   int m_st = M_IDLE, m_cad = 0, m_conv = 0;
   bit m_vld = 0;
   logic [7:0] m_hdr = 8'h00, m_dat = 8'h00;

   always #(CLK_P/2) clk = ~clk;

   wpr_supervisor #(
      .FAST_CYC(FAST), .SLOW_CYC(SLOW), .NOCONV_CYC(NOCONV), .BAND_W(2), .REG_FLAGS(1'b0),
      .SIG_STRENGTH(SS_B), .CFG_BYTE(CFG_B), .ID_BYTE(ID_B)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .link_up(link_up), .adapter_det(adapter_det),
      .en_a(en_a), .en_b(en_b), .ts_hot(ts_hot), .ts_cold(ts_cold),
      .ctrl_high(ctrl_high), .ctrl_gnd(ctrl_gnd), .die_hot(die_hot), .ilim_low(ilim_low),
      .vrect_ok(vrect_ok), .load_band(load_band), .vrect_err(vrect_err), .pkt_ready(pkt_ready),
      .pkt_valid(pkt_valid), .pkt_hdr(pkt_hdr), .pkt_data(pkt_data), .vrect_code(vrect_code),
      .out_en(out_en), .pwr_good(pwr_good), .adapter_sw(adapter_sw)
   );

   task automatic chk(input bit cond, input string tag, input int act, input int exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Reference: end-power reason and whether any shutdown applies (R6, R8)
   function automatic int ref_reason();
      if (die_hot || ilim_low) return 2;
      if (ts_hot || ts_cold || ctrl_gnd) return 3;
      if (ctrl_high || (en_a && en_b)) return 1;
      if (!en_a && !en_b && adapter_det) return 0;
      return -1;
   endfunction

   always @(posedge clk) begin
      int  rs, n_st, n_cad, n_conv;
      bit  free, silent, act, due, nc, ce, n_vld;
      logic [7:0] n_hdr, n_dat;
      cyc++;
      if (pkt_valid && pkt_ready) begin
         q_h.push_back(pkt_hdr);
         q_d.push_back(pkt_data);
         q_t.push_back(cyc);
      end
      if (!rst_n) begin
         m_st = M_IDLE; m_vld = 0; m_hdr = 0; m_dat = 0; m_cad = 0; m_conv = 0;
      end else begin
         rs     = ref_reason();
         silent = en_a && !en_b;
         free   = !m_vld || pkt_ready;
         act    = (m_st == M_CONV) || (m_st == M_RUN);
         due    = vrect_ok ? (m_cad >= SLOW - 1) : (m_cad >= FAST - 1);
         nc     = (m_conv == NOCONV);
         ce     = 0;
         n_st = m_st; n_vld = m_vld && !pkt_ready; n_hdr = m_hdr; n_dat = m_dat;
         if (!link_up) begin
            n_st = M_IDLE; n_vld = 0;
         end else if (m_st <= M_ID) begin
            if (free) begin
               if (silent) n_st = M_HALT;
               else if (rs >= 0) begin n_st = M_TERM; n_vld = 1; n_hdr = 8'h02; n_dat = 8'(rs); end
               else if (m_st == M_IDLE) begin n_st = M_SIG; n_vld = 1; n_hdr = 8'h01; n_dat = SS_B; end
               else if (m_st == M_SIG) begin n_st = M_CFG; n_vld = 1; n_hdr = 8'h51; n_dat = CFG_B; end
               else if (m_st == M_CFG) begin n_st = M_ID; n_vld = 1; n_hdr = 8'h71; n_dat = ID_B; end
               else n_st = M_CONV;
            end
         end else if (act) begin
            if (silent) n_st = M_HALT;
            else if (free && rs >= 0) begin n_st = M_TERM; n_vld = 1; n_hdr = 8'h02; n_dat = 8'(rs); end
            else if (free && nc) begin n_st = M_TERM; n_vld = 1; n_hdr = 8'h02; n_dat = 8'h08; end
            else begin
               if (free && due) begin ce = 1; n_vld = 1; n_hdr = 8'h03; n_dat = vrect_err; end
               if (m_st == M_CONV && vrect_ok) n_st = M_RUN;
            end
         end else if (m_st == M_TERM) begin
            if (free) n_st = M_HALT;
         end
         n_cad  = (!act || ce) ? 0 : ((m_cad < SLOW - 1) ? m_cad + 1 : m_cad);
         n_conv = (!act || vrect_ok) ? 0 : ((m_conv < NOCONV) ? m_conv + 1 : m_conv);
         m_st = n_st; m_vld = n_vld; m_hdr = n_hdr; m_dat = n_dat; m_cad = n_cad; m_conv = n_conv;
      end
   end

   // Every-clock comparison against the reference
   always @(negedge clk) begin
      bit exp_sw;
      int exp_code;
      if (!done) begin
         exp_sw   = (en_a && !en_b) || (!en_a && !en_b && adapter_det);
         exp_code = (m_st == M_RUN) ? int'(load_band) : 0;
         chk(pkt_valid == m_vld, "R10 stream valid", pkt_valid, m_vld);
         if (m_vld) begin
            chk(pkt_hdr == m_hdr, "R5 stream header", pkt_hdr, m_hdr);
            chk(pkt_data == m_dat, "R5 stream payload", pkt_data, m_dat);
         end
         chk(out_en == (m_st == M_RUN), "R3 out_en", out_en, m_st == M_RUN);
         chk(pwr_good == (m_st == M_RUN), "R3 pwr_good", pwr_good, m_st == M_RUN);
         chk(int'(vrect_code) == exp_code, "R4 vrect_code", vrect_code, exp_code);
         chk(adapter_sw == exp_sw, "R9 adapter_sw", adapter_sw, exp_sw);
      end
   end

   task automatic step(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic flush();
      q_h.delete(); q_d.delete(); q_t.delete();
   endtask

   task automatic drop_link();
      link_up = 0; adapter_det = 0; en_a = 0; en_b = 0; ts_hot = 0; ts_cold = 0;
      ctrl_high = 0; ctrl_gnd = 0; die_hot = 0; ilim_low = 0; vrect_ok = 0;
      load_band = 0; pkt_ready = 1;
      step(3);
      flush();
   endtask

   task automatic pop(output logic [7:0] h, output logic [7:0] d, output int t,
                      output bit got, input int lim);
      int n = 0;
      while (q_h.size() == 0 && n < lim) begin step(1); n++; end
      got = (q_h.size() != 0);
      h = 8'hxx; d = 8'hxx; t = 0;
      if (got) begin h = q_h.pop_front(); d = q_d.pop_front(); t = q_t.pop_front(); end
   endtask

   task automatic pop_ept(output logic [7:0] d, output int t, output bit got, input int lim);
      logic [7:0] h;
      int n = 0;
      got = 0; d = 8'hxx; t = 0;
      while (!got && n < lim) begin
         pop(h, d, t, got, lim);
         if (got && h != 8'h02) got = 0;
         n++;
      end
   endtask

   task automatic expect_single_ept(input logic [7:0] rsn, input string tag);
      logic [7:0] h, d; int t; bit g;
      link_up = 1;
      pop(h, d, t, g, 10);
      chk(g && h == 8'h02, {tag, " first packet is end-power"}, h, 8'h02);
      chk(d == rsn, {tag, " reason"}, d, rsn);
      step(2 * SLOW);
      chk(q_h.size() == 0, {tag, " nothing after end-power"}, q_h.size(), 0);
   endtask

   initial begin
      #(CLK_P * 60000);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] h, d;
      int t0, t1, t2, t3, tid;
      bit g;

      step(3);
      chk(pkt_valid == 0 && out_en == 0 && vrect_code == 0, "reset outputs idle (R4)",
          {pkt_valid, out_en}, 0);
      rst_n = 1;
      step(2);

      // R1, R3, R4, R5: clean session
      drop_link();
      vrect_err = 8'hF4;
      link_up = 1;
      pop(h, d, t0, g, 10);
      chk(h == 8'h01 && d == SS_B, "R1 first handshake packet", {h, d}, {8'h01, SS_B});
      pop(h, d, t0, g, 10);
      chk(h == 8'h51 && d == CFG_B, "R1 second handshake packet", {h, d}, {8'h51, CFG_B});
      pop(h, d, t0, g, 10);
      chk(h == 8'h71 && d == ID_B, "R1 third handshake packet", {h, d}, {8'h71, ID_B});
      pop(h, d, t1, g, 3 * FAST);
      chk(h == 8'h03 && d == 8'hF4, "R5 control error content", {h, d}, 16'h03F4);
      pop(h, d, t2, g, 3 * FAST);
      chk(t2 - t1 == FAST, "R5 fast spacing", t2 - t1, FAST);
      pop(h, d, t3, g, 3 * FAST);
      chk(t3 - t2 == FAST, "R5 fast spacing again", t3 - t2, FAST);
      chk(out_en == 0 && pwr_good == 0, "R3 output off before target", out_en, 0);
      chk(vrect_code == 0, "R4 no-load code before enable", vrect_code, 0);
      vrect_ok = 1;
      step(1);
      chk(out_en == 1 && pwr_good == 1, "R3 output on after target", {out_en, pwr_good}, 3);
      for (int b = 1; b < 4; b++) begin
         load_band = 2'(b);
         step(1);
         chk(int'(vrect_code) == b, "R4 code follows band", vrect_code, b);
      end
      step(SLOW + 2);
      flush();
      pop(h, d, t1, g, 3 * SLOW);
      pop(h, d, t2, g, 3 * SLOW);
      chk(g && t2 - t1 == SLOW, "R5 slow spacing on target", t2 - t1, SLOW);
      vrect_err = 8'h07;
      pop(h, d, t1, g, 3 * SLOW);
      chk(h == 8'h03 && d == 8'h07, "R5 payload follows error input", d, 8'h07);
      ts_hot = 1;
      pop_ept(d, t1, g, 10);
      chk(g && d == 8'h03, "R6 thermistor hot reason", d, 8'h03);
      step(2);
      chk(out_en == 0, "R11 output off after end-power", out_en, 0);
      flush();
      ts_hot = 0;
      step(3 * SLOW);
      chk(q_h.size() == 0, "R11 silent until link drops", q_h.size(), 0);

      // R2, R6, R8: shutdown present at start-up
      drop_link(); adapter_det = 1;
      expect_single_ept(8'h00, "R2 R6 adapter");
      drop_link(); die_hot = 1; ts_cold = 1; ctrl_high = 1;
      expect_single_ept(8'h02, "R8 die over cold over done");
      drop_link(); ts_cold = 1; en_a = 1; en_b = 1;
      expect_single_ept(8'h03, "R8 cold over both enables");
      drop_link(); en_a = 1; en_b = 1; adapter_det = 1;
      expect_single_ept(8'h01, "R8 both enables over adapter");
      drop_link(); ilim_low = 1;
      expect_single_ept(8'h02, "R6 small limit resistor");
      drop_link(); ctrl_gnd = 1;
      expect_single_ept(8'h03, "R6 grounded control");
      drop_link(); ctrl_high = 1;
      expect_single_ept(8'h01, "R6 control high");

      // R7: never converges
      drop_link();
      link_up = 1;
      pop(h, d, tid, g, 10);
      pop(h, d, tid, g, 10);
      pop(h, d, tid, g, 10);
      chk(h == 8'h71, "R7 handshake completes", h, 8'h71);
      pop_ept(d, t1, g, NOCONV + 30);
      chk(g && d == 8'h08, "R7 no-response reason", d, 8'h08);
      chk(t1 - tid == NOCONV + 2, "R7 timeout instant", t1 - tid, NOCONV + 2);
      chk(out_en == 0, "R7 output never enabled", out_en, 0);

      // R9: forced adapter mode is silent
      drop_link(); en_a = 1; adapter_det = 1; die_hot = 1;
      link_up = 1;
      step(60);
      chk(q_h.size() == 0, "R9 forced adapter sends nothing", q_h.size(), 0);
      chk(adapter_sw == 1 && out_en == 0, "R9 forced adapter switch on", {adapter_sw, out_en}, 2);

      // R9: wireless-only mode ignores the adapter
      drop_link(); en_b = 1; adapter_det = 1;
      link_up = 1;
      pop(h, d, t0, g, 10);
      chk(h == 8'h01, "R9 adapter ignored, handshake starts", h, 8'h01);
      chk(adapter_sw == 0, "R9 adapter switch off", adapter_sw, 0);
      vrect_ok = 1;
      step(3 * SLOW);
      g = 0;
      foreach (q_h[i]) if (q_h[i] == 8'h02) g = 1;
      chk(!g && out_en == 1, "R9 no end-power in wireless-only", g, 0);

      // R10: serializer stall
      drop_link(); pkt_ready = 0;
      link_up = 1;
      step(2);
      chk(pkt_valid && pkt_hdr == 8'h01, "R10 offer present", pkt_hdr, 8'h01);
      for (int i = 0; i < 4; i++) begin
         step(1);
         chk(pkt_valid && pkt_hdr == 8'h01 && pkt_data == SS_B, "R10 offer held", pkt_hdr, 8'h01);
      end
      pkt_ready = 1;
      pop(h, d, t0, g, 10);
      chk(h == 8'h01, "R1 order kept after stall", h, 8'h01);
      pop(h, d, t0, g, 10);
      chk(h == 8'h51, "R1 config after stall", h, 8'h51);

      drop_link();
      step(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule